// File: doc/BRIEF.md
# Conditional Branch Resolver

This block resolves the conditional-jump group of a 16-bit processor. Each cycle in which `instrValid` is high, it looks at the instruction word, the current program counter and the four status flags. It then decides whether the jump is taken and registers the program counter of the next instruction. The four flags are zero (Z), sign (S), carry (C) and overflow (V). A compare instruction leaves these flags as a subtraction would, with C set when no borrow occurred. The unsigned and signed relational jumps that follow a compare are therefore plain tests of these flags.

A jump word carries a four-bit opcode of `1011` in bits [15:12], a four-bit condition code in bits [11:8] and an eight-bit signed displacement in bits [7:0]. Bits [10:8] choose one of eight base conditions. Bit 11 selects the sense: when it is set the jump goes on the base condition, and when it is clear the jump goes on its negation. One base condition is constant true, which gives an unconditional jump and an explicit never-taken placeholder. Any other word is treated as a non-jump and simply advances the program counter.

The result appears one clock after the request, together with `outValid`, a taken flag and a flag that marks the word as a jump. The pipeline uses `nextPc` to redirect the fetch.

Top module: `cond_branch_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `taken`, `isBranch` and `nextPc` are all zero.
- R2: `outValid` equals `instrValid` of the previous cycle. In a cycle after `instrValid` was low, `nextPc`, `taken` and `isBranch` keep their previous values.
- R3: A word whose bits [15:12] are not `1011` gives `isBranch`=0, `taken`=0 and `nextPc` = pc + 1. A word with `1011` there gives `isBranch`=1.
- R4: A taken jump gives `nextPc` = pc + 1 + sign-extended bits [7:0].
- R5: A jump that is not taken gives `nextPc` = pc + 1.
- R6: For each base code b in bits [10:8] and any flag values, code {0,b} is taken exactly when code {1,b} is not.
- R7: Single-flag tests: `1000` jumps on Z set and `0000` on Z clear. `1001` jumps on S set and `0001` on S clear. `1010` jumps on C set (unsigned greater-or-equal) and `0010` on C clear (unsigned less-than). `1011` jumps on V set and `0011` on V clear.
- R8: Code `1100` always jumps. Code `0100` never jumps and only advances the program counter by one.
- R9: Code `1101` (unsigned greater-than) jumps when C is set and Z is clear. Code `0101` (unsigned less-or-equal) jumps in every other case.
- R10: Code `1110` (signed greater-or-equal) jumps when S equals V, and `0110` (signed less-than) jumps when they differ. Code `1111` (signed greater-than) jumps when S equals V and Z is clear, and `0111` (signed less-or-equal) jumps in every other case.
- R11: Program-counter arithmetic wraps modulo 2^16, and a displacement of `0x80` to `0xFF` counts as negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word, pc and flags are valid this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the instruction |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagC | input | 1 | Carry flag (set means no borrow) |
| flagV | input | 1 | Signed overflow flag |
| outValid | output | 1 | Result registered from a valid request |
| nextPc | output | 16 | Address of the next instruction |
| taken | output | 1 | The jump was taken |
| isBranch | output | 1 | The word was a conditional-jump word |

## Verification
The bench builds the block with its default parameters: 16-bit words and program counter, an 8-bit displacement and a 4-bit condition code. With these widths, a full sweep of all 16 condition codes against all 16 flag combinations stays small. The ends of the address space are also reachable, so `pc` = `0xFFFF` and displacements of -128 and +127 show the wrap and the sign extension directly.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Base conditions selected by the low three bits of the condition code
  typedef enum logic [2:0] {
    BC_ZERO   = 3'd0,
    BC_SIGN   = 3'd1,
    BC_CARRY  = 3'd2,
    BC_OVFL   = 3'd3,
    BC_ALWAYS = 3'd4,
    BC_UGT    = 3'd5,
    BC_SGE    = 3'd6,
    BC_SGT    = 3'd7
  } baseCondE;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic v;
  } flagsT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic isBranch;
    logic takeJump;
  } ctrlStrobesT;

endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
#(
  parameter int OP_W      = 4,
  parameter int CC_W      = 4,
  parameter int JCC_OPCODE = 'hB
) (
  input  logic                 instrValid,
  input  logic [OP_W+CC_W-1:0] opCc,
  input  flagsT                flags,
  output ctrlStrobesT          strobes
);

  localparam int BASE_W   = CC_W - 1;
  localparam int BASE_NUM = 1 << BASE_W;

  logic [OP_W-1:0]   opField;
  logic [CC_W-1:0]   ccField;
  logic [BASE_W-1:0] baseSel;
  logic              senseBit;
  logic              signLess;
  logic [BASE_NUM-1:0] baseHitVec;
  logic              baseHit;
  logic              condHit;
  logic              opMatch;

  assign opField  = opCc[OP_W+CC_W-1 -: OP_W];
  assign ccField  = opCc[CC_W-1:0];
  assign baseSel  = ccField[BASE_W-1:0];
  assign senseBit = ccField[CC_W-1];
  assign signLess = flags.s ^ flags.v;

  // Evaluate every base condition in parallel, then select one
  genvar g;
  generate
    for (g = 0; g < BASE_NUM; g++) begin : gBase
      always_comb begin
        unique case (baseCondE'(g))
          BC_ZERO:   baseHitVec[g] = flags.z;
          BC_SIGN:   baseHitVec[g] = flags.s;
          BC_CARRY:  baseHitVec[g] = flags.c;
          BC_OVFL:   baseHitVec[g] = flags.v;
          BC_ALWAYS: baseHitVec[g] = 1'b1;
          BC_UGT:    baseHitVec[g] = flags.c & ~flags.z;
          BC_SGE:    baseHitVec[g] = ~signLess;
          BC_SGT:    baseHitVec[g] = ~(signLess | flags.z);
          default:   baseHitVec[g] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign baseHit = baseHitVec[baseSel];
  // Sense bit set: jump on the base condition; clear: on its negation
  assign condHit = senseBit ? baseHit : ~baseHit;
  assign opMatch = (opField == OP_W'(JCC_OPCODE));

  always_comb begin
    strobes.load     = instrValid;
    strobes.isBranch = opMatch;
    strobes.takeJump = opMatch & condHit;
  end

endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFF_W-1:0]  offset,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              isBranch
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] offExt;
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] pcTarget;
  logic [PC_W-1:0] pcSel;

  // Both candidates are formed in parallel; the condition only drives the mux
  assign offExt   = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign pcInc    = pc + PC_W'(1);
  assign pcTarget = pcInc + offExt;
  assign pcSel    = strobes.takeJump ? pcTarget : pcInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      nextPc   <= '0;
      taken    <= 1'b0;
      isBranch <= 1'b0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        nextPc   <= pcSel;
        taken    <= strobes.takeJump;
        isBranch <= strobes.isBranch;
      end
    end
  end

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int INSTR_W    = 16,
  parameter int OFF_W      = 8,
  parameter int CC_W       = 4,
  parameter int JCC_OPCODE = 'hB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    pc,
  input  logic               flagZ,
  input  logic               flagS,
  input  logic               flagC,
  input  logic               flagV,
  output logic               outValid,
  output logic [PC_W-1:0]    nextPc,
  output logic               taken,
  output logic               isBranch
);

  localparam int OP_W = INSTR_W - CC_W - OFF_W;

  ctrlStrobesT strobes;
  flagsT       flags;

  assign flags = '{z: flagZ, s: flagS, c: flagC, v: flagV};

  cbu_ctrl #(
    .OP_W(OP_W),
    .CC_W(CC_W),
    .JCC_OPCODE(JCC_OPCODE)
  ) uCtrl (
    .instrValid(instrValid),
    .opCc(instr[INSTR_W-1 -: OP_W+CC_W]),
    .flags(flags),
    .strobes(strobes)
  );

  cbu_datapath #(
    .PC_W(PC_W),
    .OFF_W(OFF_W)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .pc(pc),
    .offset(instr[OFF_W-1:0]),
    .outValid(outValid),
    .nextPc(nextPc),
    .taken(taken),
    .isBranch(isBranch)
  );

endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int PC_W    = 16,
  parameter int INSTR_W = 16,
  parameter int OFF_W   = 8,
  parameter int CC_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrValid,
  input logic [INSTR_W-1:0] instr,
  input logic [PC_W-1:0]    pc,
  input logic               outValid,
  input logic [PC_W-1:0]    nextPc,
  input logic               taken,
  input logic               isBranch
);

  localparam int OP_W = INSTR_W - CC_W - OFF_W;

  logic [PC_W-1:0] dispExt;
  logic            jccWord;
  logic [CC_W-1:0] ccNow;

  assign dispExt = PC_W'($signed(instr[OFF_W-1:0]));
  assign jccWord = (instr[INSTR_W-1 -: OP_W] == OP_W'(4'hB));
  assign ccNow   = instr[OFF_W +: CC_W];

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> outValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> (!outValid && $stable(nextPc) && $stable(taken) && $stable(isBranch)));

  // R3
  non_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !jccWord) |=> (!taken && !isBranch && nextPc == $past(pc) + PC_W'(1)));

  // R8
  always_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && jccWord && ccNow == 4'b1100)
      |=> (taken && nextPc == $past(pc) + PC_W'(1) + $past(dispExt)));

  // R8
  never_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && jccWord && ccNow == 4'b0100)
      |=> (!taken && isBranch && nextPc == $past(pc) + PC_W'(1)));

  // R3
  taken_needs_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> isBranch);

endmodule

bind cond_branch_unit cbu_checker #(
  .PC_W(PC_W),
  .INSTR_W(INSTR_W),
  .OFF_W(OFF_W),
  .CC_W(CC_W)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .instrValid(instrValid),
  .instr(instr),
  .pc(pc),
  .outValid(outValid),
  .nextPc(nextPc),
  .taken(taken),
  .isBranch(isBranch)
);

// File: tb/sim_cond_branch_unit.sv
`timescale 1ns/1ps
module sim_cond_branch_unit;

  localparam real HALF_NS = 2.5;
  localparam int  WATCHDOG_CYCLES = 20000;

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] pc;
    logic [3:0]  f;   // {Z,S,C,V}
  } vecT;

  localparam int NVEC = 16;
  localparam vecT VECS [NVEC] = '{
    '{16'hB805, 16'h0010, 4'b1000},
    '{16'hB805, 16'h0010, 4'b0000},
    '{16'hB0FE, 16'h0100, 4'b0111},
    '{16'hB910, 16'h2000, 4'b0100},
    '{16'hB1F0, 16'h2000, 4'b0100},
    '{16'hBA03, 16'h0040, 4'b0010},
    '{16'hB203, 16'h0040, 4'b0010},
    '{16'hBB7F, 16'h1000, 4'b0001},
    '{16'hB37F, 16'h1000, 4'b1110},
    '{16'hBD08, 16'h0300, 4'b0010},
    '{16'hBD08, 16'h0300, 4'b1010},
    '{16'hB580, 16'h0300, 4'b1010},
    '{16'hBE20, 16'h0500, 4'b0101},
    '{16'hB620, 16'h0500, 4'b0100},
    '{16'hBF11, 16'h0700, 4'b1000},
    '{16'hB7EE, 16'h0700, 4'b0001}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc = '0;
  logic        flagZ = 1'b0, flagS = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic        outValid, taken, isBranch;
  logic [15:0] nextPc;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #(HALF_NS) clk = ~clk;

  cond_branch_unit u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr), .pc(pc),
    .flagZ(flagZ), .flagS(flagS), .flagC(flagC), .flagV(flagV),
    .outValid(outValid), .nextPc(nextPc), .taken(taken), .isBranch(isBranch)
  );

  // Expected jump decision, one line per condition code
  function automatic logic refTaken(input logic [3:0] cc, input logic [3:0] f);
    logic z, s, c, v;
    {z, s, c, v} = f;
    case (cc)
      4'b1000: return z;
      4'b0000: return !z;
      4'b1001: return s;
      4'b0001: return !s;
      4'b1010: return c;
      4'b0010: return !c;
      4'b1011: return v;
      4'b0011: return !v;
      4'b1100: return 1'b1;
      4'b0100: return 1'b0;
      4'b1101: return c && !z;
      4'b0101: return !c || z;
      4'b1110: return s == v;
      4'b0110: return s != v;
      4'b1111: return (s == v) && !z;
      default: return (s != v) || z;
    endcase
  endfunction

  function automatic string ccTag(input logic [3:0] cc);
    case (cc[2:0])
      3'b100:  return "R8";
      3'b101:  return "R9";
      3'b110, 3'b111: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge; the result is registered at the next rising edge
  task automatic issue(input logic [15:0] w, input logic [15:0] p, input logic [3:0] f);
    instrValid = 1'b1;
    instr = w;
    pc = p;
    {flagZ, flagS, flagC, flagV} = f;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  function automatic logic [15:0] expPc(input logic [15:0] w, input logic [15:0] p,
                                         input logic tk);
    logic [15:0] d;
    d = {{8{w[7]}}, w[7:0]};
    return tk ? (p + 16'd1 + d) : (p + 16'd1);
  endfunction

  task automatic runJump(input logic [15:0] w, input logic [15:0] p, input logic [3:0] f,
                         input string tagDecision);
    logic tk;
    tk = refTaken(w[11:8], f);
    issue(w, p, f);
    check("R2", "outValid", 32'(outValid), 32'd1);
    check("R3", "isBranch", 32'(isBranch), 32'd1);
    check(tagDecision, "taken", 32'(taken), 32'(tk));
    check(tk ? "R4" : "R5", "nextPc", 32'(nextPc), 32'(expPc(w, p, tk)));
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    check("R1", "outValid in reset", 32'(outValid), 32'd0);
    check("R1", "taken in reset", 32'(taken), 32'd0);
    check("R1", "isBranch in reset", 32'(isBranch), 32'd0);
    check("R1", "nextPc in reset", 32'(nextPc), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table for R7, R8, R9, R10
    for (int i = 0; i < NVEC; i++) begin
      runJump(VECS[i].instr, VECS[i].pc, VECS[i].f, ccTag(VECS[i].instr[11:8]));
    end

    // R2: idle cycle holds outputs while a different word sits on the input
    runJump(16'hBC20, 16'h0400, 4'b0000, "R8");
    instr = 16'hB4FF; pc = 16'h9999;
    @(negedge clk);
    check("R2", "outValid idle", 32'(outValid), 32'd0);
    check("R2", "nextPc held", 32'(nextPc), 32'h0421);
    check("R2", "taken held", 32'(taken), 32'd1);

    // R3: non-jump words advance by one whatever the flags
    issue(16'hA5FF, 16'h1234, 4'b1111);
    check("R3", "non-jump isBranch", 32'(isBranch), 32'd0);
    check("R3", "non-jump taken", 32'(taken), 32'd0);
    check("R3", "non-jump nextPc", 32'(nextPc), 32'h1235);
    issue(16'h3C05, 16'hFFFF, 4'b0000);
    check("R3", "non-jump wrap nextPc", 32'(nextPc), 32'h0000);
    check("R3", "non-jump taken 2", 32'(taken), 32'd0);

    // R11: wrap and sign extension
    runJump(16'hBC7F, 16'hFFFF, 4'b0000, "R8");
    check("R11", "wrap forward", 32'(nextPc), 32'h007F);
    runJump(16'hBC80, 16'h0000, 4'b0000, "R8");
    check("R11", "negative displacement", 32'(nextPc), 32'hFF81);
    runJump(16'hBCFF, 16'h0005, 4'b0000, "R8");
    check("R11", "displacement -1", 32'(nextPc), 32'h0005);

    // R8: never form advances by one even with a large displacement
    runJump(16'hB47F, 16'h0200, 4'b1111, "R8");
    check("R8", "never nextPc", 32'(nextPc), 32'h0201);

    // R6: sense bit inverts every base condition for every flag set
    for (int b = 0; b < 8; b++) begin
      for (int f = 0; f < 16; f++) begin
        logic tPos;
        issue({4'hB, 1'b1, 3'(b), 8'h10}, 16'h0800, 4'(f));
        tPos = taken;
        check(ccTag({1'b1, 3'(b)}), "sweep direct", 32'(tPos),
              32'(refTaken({1'b1, 3'(b)}, 4'(f))));
        issue({4'hB, 1'b0, 3'(b), 8'h10}, 16'h0800, 4'(f));
        check("R6", "sense inversion", 32'(taken), 32'(!tPos));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all R-tags) actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule